// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock waveform for an I2C master. A functional clock is divided by a programmable prescaler to form a slower module-clock enable. Two period registers set how long SCL is held low and how long it is left released. Each register holds two byte-wide values: the lower byte is used for standard and fast-mode timing, and the upper byte is used for the high-speed phase. Every period is longer than its programmed value by a fixed six units.

In high-speed operation a transfer starts in a fast-mode phase, for example to send the master code, and then moves to high-speed timing. The shift engine that owns the transfer selects the phase with a separate input. The switch takes effect only when the next low period begins, so a period that is already running keeps its length. High-speed periods count functional-clock cycles directly and do not use the prescaler. While SCL is released, the generator watches the sensed line. If a target holds the line low, the high-time count is frozen, so clock stretching lengthens the high period. Two one-cycle strobes mark the points where SCL is pulled low and where it is released, and the shift engine uses them to launch and sample data.

Top module: `scl_timing_gen`

## Requirements
- R1: In fast-mode timing, each period unit lasts `prescale + 1` functional-clock cycles.
- R2: In fast-mode timing, the low period lasts `low_period[7:0] + 6` units and the high period lasts `high_period[7:0] + 6` units, measured while SCL is sensed high.
- R3: In high-speed timing, the low period lasts `low_period[15:8] + 6` functional-clock cycles and the high period lasts `high_period[15:8] + 6` cycles, whatever the prescale value.
- R4: High-speed timing is used only when `hs_mode` and `hs_phase` are both 1. With `hs_mode` at 0, the lower bytes and the prescaler are used even if `hs_phase` is 1.
- R5: A change of `hs_phase` takes effect at the next start of a low period. The low and high periods already in progress keep their length.
- R6: While SCL is released by the generator and `scl_in` is sensed low, the high-time count does not advance, so each stalled cycle adds one cycle to the high period.
- R7: With `enable` at 0, `scl_pull_low` is 0 one cycle later and no strobe is produced. The first clock edge with `enable` at 1 starts a low period.
- R8: `fall_tick` is a one-cycle pulse in the first cycle that `scl_pull_low` is 1. `rise_tick` is a one-cycle pulse in the first cycle that `scl_pull_low` is 0 after a completed low period. Neither strobe pulses at any other time.
- R9: After reset, `scl_pull_low`, `fall_tick` and `rise_tick` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator; 0 holds it idle with SCL released |
| hs_mode | input | 1 | Allows high-speed operation |
| hs_phase | input | 1 | Selects the high-speed phase when `hs_mode` is set |
| prescale | input | PSC_W (8) | Divisor minus one for the fast-mode unit |
| low_period | input | 2*FIELD_W (16) | [7:0] fast-mode low value, [15:8] high-speed low value |
| high_period | input | 2*FIELD_W (16) | [7:0] fast-mode high value, [15:8] high-speed high value |
| scl_in | input | 1 | Sensed SCL line level |
| scl_pull_low | output | 1 | 1 drives SCL low; 0 releases it |
| fall_tick | output | 1 | Strobe at the start of each low period |
| rise_tick | output | 1 | Strobe at each release after a low period |

## Verification
The checker runs on every cycle and covers the strobes and the line drive: each strobe agrees with the drive level, the two strobes are never high together, the drive is released after `enable` falls, the drive never returns low while a stretching target holds the line, and no low period ends before the six-unit minimum. The exact period lengths cannot be seen from one cycle to the next. These are the prescale scaling, the choice between lower and upper bytes, functional-clock counting in the high-speed phase, and the point where a phase change takes effect. Only the bench scenarios can show them, because the bench measures whole low and high runs and compares them with lengths it computes from the register values.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } scl_state_e;

  // Fixed number of units added to every programmed period value
  localparam int unsigned PERIOD_OFFSET = 6;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic             bypass,
  input  logic [PSC_W-1:0] divisor,
  output logic             ce
);
  logic [PSC_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == divisor);

  always_ff @(posedge clk) begin
    if (rst || !run || restart || wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // High-speed phase counts the functional clock directly
  assign ce = run && (bypass || wrap);
endmodule

// File: rtl/scl_phase_sel.sv
module scl_phase_sel #(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned LEN_W   = FIELD_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 hs_req,
  input  logic [2*FIELD_W-1:0] low_period,
  input  logic [2*FIELD_W-1:0] high_period,
  output logic                 hs_active,
  output logic [LEN_W-1:0]     low_len,
  output logic [LEN_W-1:0]     high_len
);
  import scl_gen_pkg::*;

  logic                     hs_q;
  logic [1:0][2*FIELD_W-1:0] regs;
  logic [1:0][LEN_W-1:0]     lens;

  // Phase is sampled only when a low period begins
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b0;
    end else if (load) begin
      hs_q <= hs_req;
    end
  end

  assign regs = {high_period, low_period};

  for (genvar g = 0; g < 2; g++) begin : g_len
    logic [FIELD_W-1:0] field;
    assign field   = hs_q ? regs[g][2*FIELD_W-1:FIELD_W] : regs[g][FIELD_W-1:0];
    assign lens[g] = LEN_W'(field) + LEN_W'(PERIOD_OFFSET);
  end

  assign hs_active = hs_q;
  assign low_len   = lens[0];
  assign high_len  = lens[1];
endmodule

// File: rtl/scl_wave_fsm.sv
module scl_wave_fsm #(
  parameter int unsigned LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             ce,
  input  logic             scl_in,
  input  logic [LEN_W-1:0] low_len,
  input  logic [LEN_W-1:0] high_len,
  output logic             start_low,
  output logic             restart,
  output logic             scl_pull_low,
  output logic             fall_tick,
  output logic             rise_tick
);
  import scl_gen_pkg::*;

  scl_state_e       state_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] low_last;
  logic [LEN_W-1:0] high_last;
  logic             low_done;
  logic             high_done;

  assign low_last  = low_len - LEN_W'(1);
  assign high_last = high_len - LEN_W'(1);
  assign low_done  = (state_q == ST_LOW) && ce && (cnt_q == low_last);
  // Counting in the high phase only while the line is really high
  assign high_done = (state_q == ST_HIGH) && ce && scl_in && (cnt_q == high_last);
  assign start_low = enable && ((state_q == ST_IDLE) || high_done);
  assign restart   = start_low || low_done;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      scl_pull_low <= 1'b0;
      fall_tick    <= 1'b0;
      rise_tick    <= 1'b0;
    end else begin
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          state_q      <= ST_LOW;
          cnt_q        <= '0;
          scl_pull_low <= 1'b1;
          fall_tick    <= 1'b1;
        end
        ST_LOW: begin
          if (low_done) begin
            state_q      <= ST_HIGH;
            cnt_q        <= '0;
            scl_pull_low <= 1'b0;
            rise_tick    <= 1'b1;
          end else if (ce) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HIGH: begin
          if (high_done) begin
            state_q      <= ST_LOW;
            cnt_q        <= '0;
            scl_pull_low <= 1'b1;
            fall_tick    <= 1'b1;
          end else if (ce && scl_in) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q      <= ST_IDLE;
          cnt_q        <= '0;
          scl_pull_low <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int unsigned PSC_W   = 8,
  parameter int unsigned FIELD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 hs_mode,
  input  logic                 hs_phase,
  input  logic [PSC_W-1:0]     prescale,
  input  logic [2*FIELD_W-1:0] low_period,
  input  logic [2*FIELD_W-1:0] high_period,
  input  logic                 scl_in,
  output logic                 scl_pull_low,
  output logic                 fall_tick,
  output logic                 rise_tick
);
  localparam int unsigned LEN_W = FIELD_W + 1;

  logic             ce;
  logic             restart;
  logic             start_low;
  logic             hs_active;
  logic [LEN_W-1:0] low_len;
  logic [LEN_W-1:0] high_len;

  scl_phase_sel #(.FIELD_W(FIELD_W), .LEN_W(LEN_W)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .load       (start_low),
    .hs_req     (hs_mode && hs_phase),
    .low_period (low_period),
    .high_period(high_period),
    .hs_active  (hs_active),
    .low_len    (low_len),
    .high_len   (high_len)
  );

  scl_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk    (clk),
    .rst    (rst),
    .run    (enable),
    .restart(restart),
    .bypass (hs_active),
    .divisor(prescale),
    .ce     (ce)
  );

  scl_wave_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .ce          (ce),
    .scl_in      (scl_in),
    .low_len     (low_len),
    .high_len    (high_len),
    .start_low   (start_low),
    .restart     (restart),
    .scl_pull_low(scl_pull_low),
    .fall_tick   (fall_tick),
    .rise_tick   (rise_tick)
  );
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk #(
  parameter int unsigned CW = 16
) (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic scl_in,
  input logic scl_pull_low,
  input logic fall_tick,
  input logic rise_tick
);
  import scl_gen_pkg::*;

  logic [CW-1:0] lo_run;

  always_ff @(posedge clk) begin
    if (rst || !scl_pull_low) begin
      lo_run <= '0;
    end else if (lo_run != {CW{1'b1}}) begin
      lo_run <= lo_run + 1'b1;
    end
  end

  assert_fall_tick_drive_R8: assert property (@(posedge clk) disable iff (rst)
    fall_tick |-> scl_pull_low);

  assert_rise_tick_drive_R8: assert property (@(posedge clk) disable iff (rst)
    rise_tick |-> !scl_pull_low);

  assert_ticks_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(fall_tick && rise_tick));

  assert_disable_release_R7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!scl_pull_low && !fall_tick && !rise_tick));

  assert_stretch_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable) && !$past(rst) && !scl_pull_low && !scl_in) |=> !scl_pull_low);

  assert_low_min_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(scl_pull_low) && enable && $past(enable)) |-> (lo_run >= CW'(PERIOD_OFFSET)));
endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .scl_in      (scl_in),
  .scl_pull_low(scl_pull_low),
  .fall_tick   (fall_tick),
  .rise_tick   (rise_tick)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        hs_mode = 1'b0;
  logic        hs_phase = 1'b0;
  logic [7:0]  prescale = '0;
  logic [15:0] low_period = '0;
  logic [15:0] high_period = '0;
  logic        slave_hold = 1'b0;
  logic        scl_in;
  logic        scl_pull_low, fall_tick, rise_tick;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  int    stretch_n = 0;
  int    exp_len[$];
  string exp_tag[$];

  always #10 clk = ~clk;

  assign scl_in = !scl_pull_low && !slave_hold;

  scl_timing_gen u_dut (
    .clk(clk), .rst(rst), .enable(enable), .hs_mode(hs_mode), .hs_phase(hs_phase),
    .prescale(prescale), .low_period(low_period), .high_period(high_period),
    .scl_in(scl_in), .scl_pull_low(scl_pull_low), .fall_tick(fall_tick), .rise_tick(rise_tick)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic push(input int len, input string tag);
    exp_len.push_back(len);
    exp_tag.push_back(tag);
  endtask

  task automatic drain();
    while (exp_len.size() != 0) step(1);
    enable = 1'b0;
    step(4);
  endtask

  task automatic run_case(input logic [7:0] p, input logic [15:0] lo, input logic [15:0] hi,
                          input logic m, input logic ph, input int nper,
                          input int elo, input int ehi, input string tag);
    prescale = p; low_period = lo; high_period = hi; hs_mode = m; hs_phase = ph;
    for (int i = 0; i < nper; i++) begin
      push(elo, {tag, " low"});
      push(ehi, {tag, " high"});
    end
    enable = 1'b1;
    drain();
  endtask

  // Monitor / scoreboard: measures every drive run and compares with the queue
  initial begin
    logic prev;
    bit   run_ok;
    int   cnt;
    prev = 1'b0; run_ok = 1'b0; cnt = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (scl_pull_low != prev) begin
          if (run_ok && exp_len.size() > 0) begin
            int    e;
            string t;
            e = exp_len.pop_front();
            t = exp_tag.pop_front();
            check(cnt == e, t, cnt, e);
          end
          if (scl_pull_low) check(fall_tick && !rise_tick, "R8 fall strobe", fall_tick, 1);
          else if (enable)  check(rise_tick && !fall_tick, "R8 rise strobe", rise_tick, 1);
          cnt = 1;
          run_ok = enable;
        end else begin
          cnt++;
          if (fall_tick || rise_tick) check(1'b0, "R8 stray strobe", 1, 0);
        end
        if (!enable) run_ok = 1'b0;
        prev = scl_pull_low;
      end
    end
  end

  // Target model that stretches the clock after each release
  initial begin
    logic p;
    p = 1'b0;
    forever begin
      @(negedge clk);
      if (p && !scl_pull_low && stretch_n > 0) begin
        slave_hold = 1'b1;
        repeat (stretch_n) @(negedge clk);
        slave_hold = 1'b0;
      end
      p = scl_pull_low;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    @(negedge clk);
    check(!scl_pull_low && !fall_tick && !rise_tick, "R9 reset state", scl_pull_low, 0);
    step(1);
    rst = 1'b0;
    step(2);

    // R1 R2: minimum values, no prescaling
    run_case(8'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 3, 6, 6, "R2 min");
    // R1: prescale 3 gives four cycles per unit
    run_case(8'd3, 16'h0002, 16'h0005, 1'b0, 1'b0, 2, 32, 44, "R1 psc3");
    // R4: phase set without mode keeps lower bytes and prescaler
    run_case(8'd1, 16'h0402, 16'h0103, 1'b0, 1'b1, 2, 16, 18, "R4 mode off");
    // R3: high-speed bytes on the functional clock, prescale ignored
    run_case(8'd2, 16'h0402, 16'h0103, 1'b1, 1'b1, 2, 10, 7, "R3 hs");

    // R5: phase switch mid-period takes effect at the next low start
    prescale = 8'd1; low_period = 16'h0402; high_period = 16'h0103;
    hs_mode = 1'b1; hs_phase = 1'b0;
    push(16, "R5 fs low"); push(18, "R5 fs high");
    push(10, "R5 hs low"); push(7, "R5 hs high");
    push(10, "R5 hs low2"); push(7, "R5 hs high2");
    enable = 1'b1;
    step(3);
    hs_phase = 1'b1;
    drain();
    hs_phase = 1'b0; hs_mode = 1'b0;

    // R6: target stretches each high period by five cycles
    stretch_n = 5;
    run_case(8'd0, 16'h0001, 16'h0002, 1'b0, 1'b0, 3, 7, 13, "R6 stretch");
    stretch_n = 0;
    step(8);

    // R7: disable in the middle of a low period
    prescale = 8'd2; low_period = 16'h0010; high_period = 16'h0010;
    enable = 1'b1;
    step(5);
    @(negedge clk);
    check(scl_pull_low, "R7 low started", scl_pull_low, 1);
    step(1);
    enable = 1'b0;
    step(1);
    @(negedge clk);
    check(!scl_pull_low, "R7 release", scl_pull_low, 0);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (scl_pull_low || fall_tick || rise_tick) bad++;
      end
      check(bad == 0, "R7 idle quiet", bad, 0);
    end

    check(exp_len.size() == 0, "R2 queue drained", exp_len.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule